// File: doc/BRIEF.md
# Security Monitor State Machine

This block is the lifecycle controller that decides whether the on-chip cipher may run and with which key. Out of reset it passes through a start state, spends a fixed number of cycles clearing its RAM, and then waits in a health-check state. Software can take it out of health check only by writing a fixed sequence of three values to three sequence registers, in the right order. If the sequence is correct, the block moves to an operational state. A strap input chooses which one: secure, where the secret key is selected, or non-secure, where the default key is selected.

A wrong value, an out-of-order write or a software alarm sends the monitor to a fail state. The fail state holds until reset and keeps the cipher disabled. Software reads the current state as a 5-bit code in the status register. The encodings are fixed and do not follow a counting order, so other logic can decode them directly.

The register interface is a plain single-cycle write strobe with an address and write data. Read data is returned combinationally for the addressed register.

Top module: `sm_top`

## Requirements
- R1: While reset is asserted and in the cycle it is released, the status register (address 0) reads 0x00, the start state, with all bits above the 5-bit state field zero. cipher_en_o and key_secret_o are 0.
- R2: One cycle after reset the state becomes zeroizing (0x05). It stays there for exactly ZERO_CYCLES cycles and then becomes health check (0x06).
- R3: The state field only ever holds one of these codes: start 0x00, zeroizing 0x05, health check 0x06, fail 0x09, secure 0x0A, non-secure 0x0C.
- R4: In health check, the following three writes lead to the next state in the cycle after the last write: 0x0000AAAA to the sequence-start register (address 2), then 0x00005555 to the sequence-end register (address 3), then the same value as the end write to the sequence-check register (address 4). The next state is secure (0x0A) if secure_strap_i is 1, and non-secure (0x0C) if it is 0. Writes to other addresses between these steps do not disturb the sequence.
- R5: In health check, any of the following makes the state fail (0x09) in the next cycle: a sequence-register write with a wrong value, a check value that differs from the end value, or a sequence-register write out of order (end before start, check before end, or start twice).
- R6: A write to the command register (address 1) with bit 0 set (software alarm) makes the state fail (0x09) in the next cycle, whatever the current state.
- R7: Once in fail, the state stays fail until reset, whatever is written.
- R8: cipher_en_o is 1 exactly in the secure and non-secure states. key_secret_o is 1 exactly in the secure state.
- R9: Command writes with bit 0 clear leave the state unchanged. This includes writes with bit 1 (interrupt enable), bit 2 (bit-bank clear), bit 3 (interrupt clear) or bit 4 (tamper lock) set.
- R10: Sequence-register writes outside health check are ignored. They neither change the state nor count toward a later sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | 3 | Register address (0 status, 1 command, 2 start, 3 end, 4 check) |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the addressed register (status only, others read 0) |
| secure_strap_i | input | 1 | 1: a passed check enters secure; 0: enters non-secure |
| cipher_en_o | output | 1 | Cipher unit may operate |
| key_secret_o | output | 1 | Secret key selected (else default key) |

## Verification
A wrong internal state shows at the ports in the same cycle: the status read, cipher_en_o and key_secret_o all come straight from the state register. A step in the sequence tracker that is lost or left stale shows one write later. It appears as a fail where a pass was expected, or as an operational state that was reached without a complete sequence. After each write, the bench compares the status code and both outputs with a model of the requirements. A bad zeroize length shows as the health-check code appearing one or more cycles early or late.

// File: rtl/sm_pkg.sv
package sm_pkg;

    localparam int unsigned ADDR_W  = 3;
    localparam int unsigned STATE_W = 5;

    localparam logic [ADDR_W-1:0] REG_STATUS    = 3'd0;
    localparam logic [ADDR_W-1:0] REG_CMD       = 3'd1;
    localparam logic [ADDR_W-1:0] REG_SEQ_START = 3'd2;
    localparam logic [ADDR_W-1:0] REG_SEQ_END   = 3'd3;
    localparam logic [ADDR_W-1:0] REG_SEQ_CHECK = 3'd4;

    localparam int unsigned CMD_ALARM_BIT = 0;

    typedef enum logic [STATE_W-1:0] {
        SM_START  = 5'h00,
        SM_ZERO   = 5'h05,
        SM_HEALTH = 5'h06,
        SM_FAIL   = 5'h09,
        SM_SECURE = 5'h0A,
        SM_OPEN   = 5'h0C
    } sm_state_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_END   = 2'd2
    } seq_phase_e;

endpackage

// File: rtl/sm_zero_timer.sv
module sm_zero_timer #(
    parameter int unsigned ZERO_CYCLES = 16,
    localparam int unsigned CNT_W = (ZERO_CYCLES > 1) ? $clog2(ZERO_CYCLES) : 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic done_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_regs_t;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(ZERO_CYCLES - 1);

    tmr_regs_t d, q;

    always_comb begin
        d = q;
        if (!run_i) begin
            d.cnt = '0;
        end else if (q.cnt != LAST) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    assign done_o = run_i && (q.cnt == LAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/sm_seq_checker.sv
module sm_seq_checker
    import sm_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter logic [DATA_W-1:0] START_PAT = 'hAAAA,
    parameter logic [DATA_W-1:0] END_PAT   = 'h5555
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              active_i,
    input  logic              wr_start_i,
    input  logic              wr_end_i,
    input  logic              wr_check_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              pass_o,
    output logic              fail_o
);

    typedef struct packed {
        seq_phase_e        phase;
        logic [DATA_W-1:0] end_val;
    } seq_regs_t;

    seq_regs_t d, q;

    always_comb begin
        d      = q;
        pass_o = 1'b0;
        fail_o = 1'b0;
        if (!active_i) begin
            d.phase = PH_IDLE;
        end else if (wr_start_i) begin
            if (q.phase == PH_IDLE && wdata_i == START_PAT) begin
                d.phase = PH_START;
            end else begin
                fail_o  = 1'b1;
                d.phase = PH_IDLE;
            end
        end else if (wr_end_i) begin
            if (q.phase == PH_START && wdata_i == END_PAT) begin
                d.phase   = PH_END;
                d.end_val = wdata_i;
            end else begin
                fail_o  = 1'b1;
                d.phase = PH_IDLE;
            end
        end else if (wr_check_i) begin
            if (q.phase == PH_END && wdata_i == q.end_val) begin
                pass_o = 1'b1;
            end else begin
                fail_o = 1'b1;
            end
            d.phase = PH_IDLE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.phase   <= PH_IDLE;
            q.end_val <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/sm_top.sv
module sm_top
    import sm_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ZERO_CYCLES = 16,
    parameter logic [DATA_W-1:0] START_PAT = 'hAAAA,
    parameter logic [DATA_W-1:0] END_PAT   = 'h5555
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_wr_i,
    input  logic [2:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              secure_strap_i,
    output logic              cipher_en_o,
    output logic              key_secret_o
);

    localparam int unsigned PAD_W = DATA_W - STATE_W;

    typedef struct packed {
        sm_state_e state;
    } top_regs_t;

    top_regs_t d, q;

    logic      wr_cmd, wr_start, wr_end, wr_check, alarm;
    logic      zero_done, seq_pass, seq_fail;
    sm_state_e cur_state;

    assign wr_cmd   = bus_wr_i && (bus_addr_i == REG_CMD);
    assign wr_start = bus_wr_i && (bus_addr_i == REG_SEQ_START);
    assign wr_end   = bus_wr_i && (bus_addr_i == REG_SEQ_END);
    assign wr_check = bus_wr_i && (bus_addr_i == REG_SEQ_CHECK);
    assign alarm    = wr_cmd && bus_wdata_i[CMD_ALARM_BIT];

    sm_zero_timer #(
        .ZERO_CYCLES(ZERO_CYCLES)
    ) u_timer (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (q.state == SM_ZERO),
        .done_o(zero_done)
    );

    sm_seq_checker #(
        .DATA_W   (DATA_W),
        .START_PAT(START_PAT),
        .END_PAT  (END_PAT)
    ) u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .active_i  (q.state == SM_HEALTH),
        .wr_start_i(wr_start),
        .wr_end_i  (wr_end),
        .wr_check_i(wr_check),
        .wdata_i   (bus_wdata_i),
        .pass_o    (seq_pass),
        .fail_o    (seq_fail)
    );

    always_comb begin
        d = q;
        unique case (q.state)
            SM_START:  d.state = SM_ZERO;
            SM_ZERO:   if (zero_done) d.state = SM_HEALTH;
            SM_HEALTH: begin
                if (seq_fail) begin
                    d.state = SM_FAIL;
                end else if (seq_pass) begin
                    d.state = secure_strap_i ? SM_SECURE : SM_OPEN;
                end
            end
            SM_SECURE, SM_OPEN, SM_FAIL: d.state = q.state;
            default:   d.state = SM_FAIL;
        endcase
        if (alarm) begin
            d.state = SM_FAIL;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.state <= SM_START;
        end else begin
            q <= d;
        end
    end

    assign cur_state    = q.state;
    assign cipher_en_o  = (q.state == SM_SECURE) || (q.state == SM_OPEN);
    assign key_secret_o = (q.state == SM_SECURE);
    assign bus_rdata_o  = (bus_addr_i == REG_STATUS) ? {{PAD_W{1'b0}}, q.state} : '0;

endmodule

// File: rtl/sm_checker.sv
module sm_checker
    import sm_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_wr_i,
    input logic [2:0]        bus_addr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic              cipher_en_o,
    input logic              key_secret_o,
    input sm_state_e         cur_state
);

    always @(posedge clk_i) begin
        if (rst_ni) begin
            assert_legal_code_R3: assert (cur_state inside {SM_START, SM_ZERO, SM_HEALTH,
                                                            SM_FAIL, SM_SECURE, SM_OPEN})
                else $error("illegal state code %h", cur_state);
        end
    end

    assert_alarm_fails_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == REG_CMD && bus_wdata_i[CMD_ALARM_BIT]) |=> (cur_state == SM_FAIL));

    assert_fail_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_state == SM_FAIL) |=> (cur_state == SM_FAIL));

    assert_fail_no_cipher_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_state == SM_FAIL) |-> !cipher_en_o);

    assert_key_needs_cipher_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        key_secret_o |-> cipher_en_o);

    assert_exit_health_by_check_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_state == SM_HEALTH && !(bus_wr_i && bus_addr_i == REG_SEQ_CHECK))
        |=> (cur_state inside {SM_HEALTH, SM_FAIL}));

    assert_zero_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_state == SM_ZERO) |-> ($past(cur_state) inside {SM_START, SM_ZERO}));

endmodule

bind sm_top sm_checker #(.DATA_W(DATA_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .cipher_en_o (cipher_en_o),
    .key_secret_o(key_secret_o),
    .cur_state   (cur_state)
);

// File: tb/test_sm_top.sv
`timescale 1ns/1ps
module test_sm_top;

    localparam int DW = 32;
    localparam int ZC = 16;
    localparam logic [4:0] S_START = 5'h00, S_ZERO = 5'h05, S_HEALTH = 5'h06,
                           S_FAIL = 5'h09, S_SEC = 5'h0A, S_OPEN = 5'h0C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr = 1'b0;
    logic [2:0]    addr = 3'd0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          strap = 1'b1;
    logic          cen, ksec;

    int checks = 0;
    int fails  = 0;

    // bench model
    logic [4:0]  m_state;
    int          m_phase;
    logic [31:0] m_end;

    always #2.5 clk = ~clk;

    sm_top #(.DATA_W(DW), .ZERO_CYCLES(ZC)) i_sm_top (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .secure_strap_i(strap),
        .cipher_en_o(cen), .key_secret_o(ksec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_cen(input logic [4:0] s);
        return (s == S_SEC) || (s == S_OPEN);
    endfunction

    task automatic check_all(input string req);
        addr = 3'd0;
        #0.1;
        chk(req, rdata, {27'd0, m_state});
        chk({req, "/R8 cipher_en"}, {31'd0, cen}, {31'd0, exp_cen(m_state)});
        chk({req, "/R8 key_secret"}, {31'd0, ksec}, {31'd0, m_state == S_SEC});
    endtask

    function automatic void model_write(input logic [2:0] a, input logic [31:0] v);
        if (a == 3'd1 && v[0]) begin
            m_state = S_FAIL;
            return;
        end
        if (m_state != S_HEALTH) return;
        if (a == 3'd2) begin
            if (m_phase == 0 && v == 32'hAAAA) m_phase = 1;
            else begin m_state = S_FAIL; m_phase = 0; end
        end else if (a == 3'd3) begin
            if (m_phase == 1 && v == 32'h5555) begin m_phase = 2; m_end = v; end
            else begin m_state = S_FAIL; m_phase = 0; end
        end else if (a == 3'd4) begin
            if (m_phase == 2 && v == m_end) m_state = strap ? S_SEC : S_OPEN;
            else m_state = S_FAIL;
            m_phase = 0;
        end
    endfunction

    task automatic bus_write(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr = 1'b0;
        model_write(a, v);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr = 1'b0;
        m_state = S_START; m_phase = 0; m_end = '0;
        repeat (2) @(negedge clk);
        check_all("R1 reset state");
        rst_n = 1'b1;
        check_all("R1 state at release");
    endtask

    task automatic reset_to_health();
        do_reset();
        repeat (ZC + 1) @(negedge clk);
        m_state = S_HEALTH;
    endtask

    task automatic good_seq(input string req);
        bus_write(3'd2, 32'hAAAA); check_all({req, " after start"});
        bus_write(3'd3, 32'h5555); check_all({req, " after end"});
        bus_write(3'd4, 32'h5555); check_all(req);
    endtask

    function automatic void summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endfunction

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        int zc;
        void'($urandom(32'h5EC0_0001));

        // R1, R2: reset and zeroize duration
        do_reset();
        @(negedge clk); m_state = S_ZERO; check_all("R2 zeroize entry");
        zc = 1;
        for (int i = 0; i < 3 * ZC; i++) begin
            @(negedge clk);
            addr = 3'd0; #0.1;
            if (rdata[4:0] == S_ZERO) zc++;
            else break;
        end
        chk("R2 zeroize cycles", zc, ZC);
        m_state = S_HEALTH; check_all("R2 health after zeroize");

        // R4 secure via strap=1
        strap = 1'b1; good_seq("R4 secure pass");
        // R10 seq writes in operational state ignored
        bus_write(3'd4, 32'h1234); check_all("R10 check write in secure ignored");
        bus_write(3'd3, 32'h0); check_all("R10 end write in secure ignored");
        // R6 alarm from secure, R7 sticky
        bus_write(3'd1, 32'h1); check_all("R6 alarm in secure");
        good_seq("R7 fail sticky");
        bus_write(3'd1, 32'h1E); check_all("R7 fail sticky cmd");

        // R4 non-secure via strap=0 with interleaved writes
        reset_to_health(); strap = 1'b0;
        bus_write(3'd2, 32'hAAAA);
        bus_write(3'd0, 32'hFFFF); check_all("R4 interleaved status write");
        bus_write(3'd1, 32'h1E); check_all("R9 cmd bits 1-4 keep state");
        bus_write(3'd3, 32'h5555);
        bus_write(3'd4, 32'h5555); check_all("R4 non-secure pass");
        strap = 1'b1;

        // R5 directed failures
        reset_to_health();
        bus_write(3'd3, 32'h5555); check_all("R5 end before start");
        reset_to_health();
        bus_write(3'd2, 32'hAAAA); bus_write(3'd3, 32'h5555);
        bus_write(3'd4, 32'h5556); check_all("R5 check mismatch");
        reset_to_health();
        bus_write(3'd2, 32'hAAAA); bus_write(3'd2, 32'hAAAA); check_all("R5 start twice");
        reset_to_health();
        bus_write(3'd4, 32'h5555); check_all("R5 check first");
        reset_to_health();
        bus_write(3'd2, 32'hAAAB); check_all("R5 wrong start value");

        // R9 in health
        reset_to_health();
        bus_write(3'd1, 32'h02); bus_write(3'd1, 32'h04);
        bus_write(3'd1, 32'h08); bus_write(3'd1, 32'h10); check_all("R9 cmd bits in health");

        // R6 alarm during zeroize
        do_reset();
        repeat (3) @(negedge clk);
        m_state = S_ZERO;
        bus_write(3'd1, 32'h1); check_all("R6 alarm in zeroize");

        // R10 start write during zeroize does not count
        do_reset();
        repeat (2) @(negedge clk);
        m_state = S_ZERO;
        bus_write(3'd2, 32'hAAAA); check_all("R10 start in zeroize ignored");
        repeat (ZC + 2) @(negedge clk);
        m_state = S_HEALTH; check_all("R10 health reached");
        bus_write(3'd3, 32'h5555); check_all("R10 earlier start not counted");

        // random trials
        for (int t = 0; t < 60; t++) begin
            reset_to_health();
            strap = 1'($urandom_range(0, 1));
            for (int k = 0; k < 8; k++) begin
                logic [2:0]  a;
                logic [31:0] v;
                int          pick;
                pick = $urandom_range(0, 9);
                if (pick < 6) begin
                    a = 3'(2 + ((m_phase + (pick == 5 ? 1 : 0)) % 3));
                    v = (a == 3'd2) ? 32'hAAAA : 32'h5555;
                    if (pick == 4) v = v ^ (32'd1 << $urandom_range(0, 31));
                end else if (pick < 8) begin
                    a = 3'd1; v = $urandom() & 32'h1E;
                    if ($urandom_range(0, 7) == 0) v[0] = 1'b1;
                end else begin
                    a = 3'($urandom_range(0, 7)); v = $urandom();
                end
                bus_write(a, v);
                check_all("R4/R5/R6/R9 random");
            end
        end

        summary();
        $finish;
    end

endmodule